// File: doc/BRIEF.md
# Operand Address Sequencer

This block produces memory operand addresses for tight signal-processing loops without taking any cycles from the arithmetic datapath. It keeps four independent address channels. Each channel has a current pointer, a base, a length, a signed step and an update mode. A loop selects a channel and raises an access strobe. In that same cycle the block presents the channel's current address. At the next clock edge it advances the channel by the selected rule, so a new address can be produced on every cycle with no stall.

Three update rules are available. The first is plain post-increment by the signed step. The second is modulo wrap-around inside a window of `length` entries starting at `base`, which serves FIR delay lines and sample FIFOs. The third is bit-reversed stepping, which visits the entries of a power-of-two FFT buffer in reversed-index order. All channel fields are loaded through a small write port that selects the channel and the field.

Top module: `agu_core`

## Requirements
- R1: While reset is held low, and for the first cycles after it is released, every channel field is zero and the mode is linear. So `addr_o` is 0 for every channel selection.
- R2: `addr_o` always shows the current address of the channel on `acc_sel`, combinationally. `addr_vld` is high exactly in the cycles where `acc_en` is high.
- R3: In linear mode (mode code 0), a strobe loads the pointer with (pointer + step) modulo 2^16 at the next edge. The step is a signed 16-bit value, and the address shown during the strobe is the pointer from before the update.
- R4: In circular mode (mode code 1) with a non-negative step, the next pointer is pointer + step. If that value is at or above base + length, length is subtracted from it.
- R5: In circular mode with a negative step, the next pointer is pointer + step. If that value is below base, length is added to it.
- R6: In bit-reversed mode (mode code 2), the pointer acts as an index counter. The address is base plus the low log2(length) bits of the counter in reversed order. A strobe advances the counter by one modulo length, and the step is not used. With length 8 the address offsets run 0,4,2,6,1,5,3,7 and then repeat.
- R7: A channel that is neither strobed nor written keeps its pointer. Strobing one channel leaves the other channels unchanged.
- R8: When a pointer write and a strobe hit the same channel in the same cycle, the written value wins. A write to any other field of the strobed channel in that cycle does not change that strobe's update, which uses the old field values.
- R9: Write field codes are 0 for pointer, 1 for base, 2 for length, 3 for step and 4 for mode (the low two bits of the data). Mode code 3 behaves as linear. In linear mode the base and length fields have no effect on the addresses.
- R10: Strobes may be issued on every cycle, switching between channels freely. Each strobe yields its address in that cycle and advances only its own channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Field write enable |
| cfg_sel | input | 2 | Channel targeted by the write |
| cfg_field | input | 3 | Field code of the write (see R9) |
| cfg_wdata | input | 16 | Write data |
| acc_en | input | 1 | Access strobe |
| acc_sel | input | 2 | Channel selected for access and shown on `addr_o` |
| addr_o | output | 16 | Current address of the selected channel |
| addr_vld | output | 1 | High while a strobe is presented |

## Verification
A field write and an access strobe can land on the same channel in the same cycle. The bench provokes this by raising `cfg_we` and `acc_en` together on one channel, once with a pointer write and once with a step write. A behavioural reference model, which advances the channel first and then applies the write, judges the following cycles. A circular channel with a negative step and a bit-reversed channel of several lengths run alongside this, so the wrap corrections and the reversal are also compared on every clock.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    AM_LINEAR = 2'd0,
    AM_CIRC   = 2'd1,
    AM_BITREV = 2'd2,
    AM_SPARE  = 2'd3
  } agu_mode_e;

  typedef enum logic [2:0] {
    FLD_PTR  = 3'd0,
    FLD_BASE = 3'd1,
    FLD_LEN  = 3'd2,
    FLD_STEP = 3'd3,
    FLD_MODE = 3'd4
  } agu_field_e;

endpackage

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] idx_i,
  input  logic [AW-1:0] len_i,
  output logic [AW-1:0] rev_o
);
  localparam int KW = $clog2(AW + 1);

  logic [KW-1:0] width_k;
  logic [KW-1:0] shamt;
  logic [AW-1:0] rev_full;

  // log2 of a power-of-two length: index of the highest set bit
  always_comb begin
    width_k = '0;
    for (int i = 0; i < AW; i++) begin
      if (len_i[i]) width_k = KW'(i);
    end
  end

  always_comb begin
    for (int i = 0; i < AW; i++) begin
      rev_full[i] = idx_i[AW-1-i];
    end
  end

  assign shamt = KW'(AW) - width_k;
  assign rev_o = rev_full >> shamt;

endmodule

// File: rtl/agu_next.sv
module agu_next
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  input  logic [AW-1:0] step_i,
  input  agu_mode_e     mode_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] next_o
);
  localparam int EW = AW + 3;

  logic [AW-1:0]        rev_off;
  logic [AW-1:0]        lin_next;
  logic [AW-1:0]        br_next;
  logic signed [EW-1:0] sum_x;
  logic signed [EW-1:0] lo_x;
  logic signed [EW-1:0] hi_x;
  logic signed [EW-1:0] len_x;
  logic signed [EW-1:0] circ_x;

  agu_bitrev #(.AW(AW)) u_rev (
    .idx_i (ptr_i),
    .len_i (len_i),
    .rev_o (rev_off)
  );

  assign lin_next = ptr_i + step_i;
  assign br_next  = (ptr_i + AW'(1)) & (len_i - AW'(1));

  // circular: widened signed sum, one correction by length
  always_comb begin
    sum_x = {3'b000, ptr_i} + {{3{step_i[AW-1]}}, step_i};
    lo_x  = {3'b000, base_i};
    len_x = {3'b000, len_i};
    hi_x  = lo_x + len_x;
    if (!step_i[AW-1] && (sum_x >= hi_x)) begin
      circ_x = sum_x - len_x;
    end else if (step_i[AW-1] && (sum_x < lo_x)) begin
      circ_x = sum_x + len_x;
    end else begin
      circ_x = sum_x;
    end
  end

  always_comb begin
    unique case (mode_i)
      AM_CIRC: begin
        addr_o = ptr_i;
        next_o = circ_x[AW-1:0];
      end
      AM_BITREV: begin
        addr_o = base_i + rev_off;
        next_o = br_next;
      end
      default: begin
        addr_o = ptr_i;
        next_o = lin_next;
      end
    endcase
  end

endmodule

// File: rtl/agu_chan.sv
module agu_chan
  import agu_pkg::*;
#(
  parameter int AW = 16,
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_field,
  input  logic [AW-1:0] wr_data,
  input  logic          adv,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] len_q,
  output logic [AW-1:0] step_q,
  output agu_mode_e     mode_q,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] upd_ptr;
  logic [AW-1:0] ptr_d;
  logic          ptr_ce, base_ce, len_ce, step_ce, mode_ce;

  agu_next #(.AW(AW)) u_next (
    .ptr_i  (ptr_q),
    .base_i (base_q),
    .len_i  (len_q),
    .step_i (step_q),
    .mode_i (mode_q),
    .addr_o (addr),
    .next_o (upd_ptr)
  );

  // next state: a pointer write overrides the strobe update
  always_comb begin
    base_ce = wr_en && (wr_field == FW'(FLD_BASE));
    len_ce  = wr_en && (wr_field == FW'(FLD_LEN));
    step_ce = wr_en && (wr_field == FW'(FLD_STEP));
    mode_ce = wr_en && (wr_field == FW'(FLD_MODE));
    ptr_ce  = adv || (wr_en && (wr_field == FW'(FLD_PTR)));
    ptr_d   = upd_ptr;
    if (wr_en && (wr_field == FW'(FLD_PTR))) ptr_d = wr_data;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ptr_q  <= '0;
      base_q <= '0;
      len_q  <= '0;
      step_q <= '0;
      mode_q <= AM_LINEAR;
    end else begin
      if (ptr_ce)  ptr_q  <= ptr_d;
      if (base_ce) base_q <= wr_data;
      if (len_ce)  len_q  <= wr_data;
      if (step_ce) step_q <= wr_data;
      if (mode_ce) mode_q <= agu_mode_e'(wr_data[1:0]);
    end
  end

endmodule

// File: rtl/agu_core.sv
module agu_core
  import agu_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int FW  = 3,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_sel,
  input  logic [FW-1:0] cfg_field,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          acc_en,
  input  logic [SW-1:0] acc_sel,
  output logic [AW-1:0] addr_o,
  output logic          addr_vld
);
  logic [1:0]                 rst_sync;
  logic                       srst_n;
  logic [NCH-1:0][AW-1:0]     ptr_all;
  logic [NCH-1:0][AW-1:0]     base_all;
  logic [NCH-1:0][AW-1:0]     len_all;
  logic [NCH-1:0][AW-1:0]     step_all;
  logic [NCH-1:0][1:0]        mode_all;
  logic [NCH-1:0][AW-1:0]     addr_all;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    agu_mode_e mode_c;
    agu_chan #(.AW(AW), .FW(FW)) u_ch (
      .clk      (clk),
      .srst_n   (srst_n),
      .wr_en    (cfg_we && (cfg_sel == SW'(c))),
      .wr_field (cfg_field),
      .wr_data  (cfg_wdata),
      .adv      (acc_en && (acc_sel == SW'(c))),
      .ptr_q    (ptr_all[c]),
      .base_q   (base_all[c]),
      .len_q    (len_all[c]),
      .step_q   (step_all[c]),
      .mode_q   (mode_c),
      .addr     (addr_all[c])
    );
    assign mode_all[c] = mode_c;
  end

  assign addr_o   = addr_all[acc_sel];
  assign addr_vld = acc_en;

endmodule

// File: rtl/agu_core_chk.sv
module agu_core_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int FW  = 3,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   srst_n,
  input logic                   cfg_we,
  input logic [SW-1:0]          cfg_sel,
  input logic [FW-1:0]          cfg_field,
  input logic [AW-1:0]          cfg_wdata,
  input logic                   acc_en,
  input logic [SW-1:0]          acc_sel,
  input logic [AW-1:0]          addr_o,
  input logic [NCH-1:0][AW-1:0] ptr_all,
  input logic [NCH-1:0][AW-1:0] base_all,
  input logic [NCH-1:0][AW-1:0] len_all,
  input logic [NCH-1:0][AW-1:0] step_all,
  input logic [NCH-1:0][1:0]    mode_all
);
  logic [SW-1:0] asel_q, wsel_q;
  logic [AW-1:0] s_ptr, s_base, s_len, s_step;
  logic [1:0]    s_mode;
  logic [AW:0]   s_hi, s_mag;
  logic          in_win, step_ok;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      asel_q <= '0;
      wsel_q <= '0;
    end else begin
      asel_q <= acc_sel;
      wsel_q <= cfg_sel;
    end
  end

  assign s_ptr   = ptr_all[acc_sel];
  assign s_base  = base_all[acc_sel];
  assign s_len   = len_all[acc_sel];
  assign s_step  = step_all[acc_sel];
  assign s_mode  = mode_all[acc_sel];
  assign s_hi    = {1'b0, s_base} + {1'b0, s_len};
  assign s_mag   = s_step[AW-1] ? ({1'b0, ~s_step} + 1'b1) : {1'b0, s_step};
  assign in_win  = (s_ptr >= s_base) && ({1'b0, s_ptr} < s_hi);
  assign step_ok = (s_mag <= {1'b0, s_len}) && (s_hi <= {1'b1, {AW{1'b0}}});

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (addr_o == '0));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (acc_en && !cfg_we && (s_mode == 2'd0)) |=> (ptr_all[asel_q] == $past(s_ptr + s_step)));

  assert_circ_window_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (acc_en && !cfg_we && (s_mode == 2'd1) && in_win && step_ok)
    |=> ((ptr_all[asel_q] >= $past(s_base)) && ({1'b0, ptr_all[asel_q]} < $past(s_hi))));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (!acc_en && !cfg_we) |=> ((acc_sel != asel_q) || $stable(addr_o)));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (cfg_we && (cfg_field == FW'(0))) |=> (ptr_all[wsel_q] == $past(cfg_wdata)));

endmodule

bind agu_core agu_core_chk #(.NCH(NCH), .AW(AW), .FW(FW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .srst_n    (srst_n),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_field (cfg_field),
  .cfg_wdata (cfg_wdata),
  .acc_en    (acc_en),
  .acc_sel   (acc_sel),
  .addr_o    (addr_o),
  .ptr_all   (ptr_all),
  .base_all  (base_all),
  .len_all   (len_all),
  .step_all  (step_all),
  .mode_all  (mode_all)
);

// File: tb/agu_core_test.sv
module agu_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [2:0]  cfg_field;
  logic [15:0] cfg_wdata;
  logic        acc_en;
  logic [1:0]  acc_sel;
  logic [15:0] addr_o;
  logic        addr_vld;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  string cur_req = "R1";

  int mptr[4], mbase[4], mlen[4], mstep[4], mmode[4];

  agu_core uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .acc_en(acc_en),
    .acc_sel(acc_sel), .addr_o(addr_o), .addr_vld(addr_vld)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int klog(int len);
    int k = 0;
    for (int i = 0; i < 16; i++) if (len[i]) k = i;
    return k;
  endfunction

  function automatic int rev_bits(int v, int k);
    int r = 0;
    for (int i = 0; i < k; i++) if (v[i]) r |= (1 << (k - 1 - i));
    return r;
  endfunction

  function automatic int exp_addr(int c);
    if (mmode[c] == 2) return (mbase[c] + rev_bits(mptr[c], klog(mlen[c]))) & 'hFFFF;
    return mptr[c];
  endfunction

  task automatic model_update();
    int c, s, hi;
    if (acc_en) begin
      c = int'(acc_sel);
      case (mmode[c])
        1: begin
          s  = mptr[c] + mstep[c];
          hi = mbase[c] + mlen[c];
          if (mstep[c] >= 0 && s >= hi) s = s - mlen[c];
          else if (mstep[c] < 0 && s < mbase[c]) s = s + mlen[c];
          mptr[c] = s & 'hFFFF;
        end
        2: mptr[c] = (mptr[c] + 1) & ((mlen[c] - 1) & 'hFFFF);
        default: mptr[c] = (mptr[c] + mstep[c]) & 'hFFFF;
      endcase
    end
    if (cfg_we) begin
      c = int'(cfg_sel);
      case (cfg_field)
        3'd0: mptr[c]  = int'(cfg_wdata);
        3'd1: mbase[c] = int'(cfg_wdata);
        3'd2: mlen[c]  = int'(cfg_wdata);
        3'd3: mstep[c] = int'($signed(cfg_wdata));
        3'd4: mmode[c] = int'(cfg_wdata[1:0]);
        default: ;
      endcase
    end
  endtask

  task automatic check_outputs();
    int e;
    e = exp_addr(int'(acc_sel));
    checks++;
    if (int'(addr_o) != e) begin
      errors++;
      $display("FAIL %s ch%0d addr actual=%h expected=%h", cur_req, acc_sel, addr_o, e[15:0]);
    end
    checks++;
    if (addr_vld !== acc_en) begin
      errors++;
      $display("FAIL R2 addr_vld actual=%b expected=%b", addr_vld, acc_en);
    end
  endtask

  task automatic tick();
    #1 check_outputs();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic drive(input bit we, input int cs, input int fld, input int data,
                       input bit en, input int as);
    cfg_we    = we;
    cfg_sel   = cs[1:0];
    cfg_field = fld[2:0];
    cfg_wdata = data[15:0];
    acc_en    = en;
    acc_sel   = as[1:0];
    tick();
  endtask

  task automatic wr(input int cs, input int fld, input int data);
    drive(1'b1, cs, fld, data, 1'b0, cs);
  endtask

  task automatic acc(input int ch, input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 0, 1'b1, ch);
  endtask

  task automatic idle_sweep();
    for (int c = 0; c < 4; c++) drive(1'b0, 0, 0, 0, 1'b0, c);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      mptr[c] = 0; mbase[c] = 0; mlen[c] = 0; mstep[c] = 0; mmode[c] = 0;
    end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_field = '0;
    cfg_wdata = '0; acc_en = 1'b0; acc_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state visible on every channel, also through sync release
    cur_req = "R1";
    idle_sweep();
    idle_sweep();

    // R3: linear post-increment, positive then negative wrap through zero
    cur_req = "R3";
    wr(0, 0, 'h0100);
    wr(0, 3, 3);
    acc(0, 6);
    wr(0, 0, 1);
    wr(0, 3, 'hFFFE);
    acc(0, 3);

    // R9: base/length ignored in linear mode, spare mode code acts linear
    cur_req = "R9";
    wr(0, 1, 'h5555);
    wr(0, 2, 8);
    acc(0, 2);
    wr(0, 4, 3);
    wr(0, 3, 7);
    acc(0, 3);

    // R4: circular, non-negative steps
    cur_req = "R4";
    wr(1, 4, 1);
    wr(1, 1, 'h0200);
    wr(1, 2, 5);
    wr(1, 3, 1);
    wr(1, 0, 'h0200);
    acc(1, 12);
    wr(1, 2, 8);
    wr(1, 3, 3);
    wr(1, 0, 'h0206);
    acc(1, 8);

    // R5: circular, negative step below base
    cur_req = "R5";
    wr(1, 2, 5);
    wr(1, 3, 'hFFFE);
    wr(1, 0, 'h0201);
    acc(1, 8);

    // R6: bit-reversed over lengths 8, 16, 1
    cur_req = "R6";
    wr(2, 4, 2);
    wr(2, 1, 'h1000);
    wr(2, 2, 8);
    wr(2, 3, 5);
    wr(2, 0, 0);
    acc(2, 10);
    wr(2, 2, 16);
    wr(2, 0, 0);
    acc(2, 18);
    wr(2, 2, 1);
    acc(2, 2);

    // R7: other channels hold while one is strobed
    cur_req = "R7";
    idle_sweep();
    wr(3, 3, 1);
    acc(3, 4);
    idle_sweep();

    // R8: pointer write collides with strobe; step write collides with strobe
    cur_req = "R8";
    wr(1, 3, 1);
    drive(1'b1, 1, 0, 'h0203, 1'b1, 1);
    acc(1, 1);
    drive(1'b1, 1, 3, 2, 1'b1, 1);
    acc(1, 3);
    drive(1'b1, 2, 0, 3, 1'b1, 2);
    acc(2, 2);

    // R10: strobes every cycle, channel changing each cycle
    cur_req = "R10";
    for (int i = 0; i < 12; i++) drive(1'b0, 0, 0, 0, 1'b1, i % 4);
    idle_sweep();

    // R2: strobe low, selection still shows addresses and valid stays low
    cur_req = "R2";
    idle_sweep();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule